// File: doc/BRIEF.md
# H-Bridge Dual-Carrier PWM Generator

This block produces the four gate signals of a full-bridge DC motor chopper. Each bridge leg has its own triangular carrier: an up/down counter that rises from zero to the carrier period and falls back to zero. Each leg compares its carrier against its own buffered duty value. The result is a pulse centred in each carrier cycle. Each leg produces an upper and a lower gate signal that are complementary, with a programmable dead interval inserted before every turn-on edge.

Duty values are captured into a shadow stage on every clock. They reach the comparators only when the carrier sits at zero, so a pulse is never cut mid-cycle. The carrier period is captured at the same point. One clock after each zero point the block raises a one-cycle strobe, which an external converter uses to sample the speed command. In bipolar mode the right leg derives its duty from the left command, as period minus command. A mid-scale command then gives zero average bridge voltage.

Top module: `hbridge_pwm_gen`

## Requirements
- R1: While enabled with period P >= 1, each carrier counts 0, 1, ..., P, P-1, ..., 1 and repeats, so one carrier cycle lasts 2P clocks. The two carriers stay in step.
- R2: `adc_soc` is high for exactly one clock, in the clock after the carrier value is 0. It therefore pulses once per carrier cycle, and never while the period is 0.
- R3: Before its dead-band delay, a leg's upper gate is high in the clock after each clock in which the carrier value is below that leg's active compare value. With no dead band, a leg whose compare value is c (1 <= c <= P) is therefore high for 2c-2 of the 2P-1 clocks that follow a strobe, and for all of them when c > P. A compare value of 0 keeps the upper gate low.
- R4: Duty inputs are sampled into a shadow on every clock. The active compare value takes the shadow only in a clock where the carrier is 0, so a duty written in the clock of a strobe first shapes the carrier cycle after the current one.
- R5: The lower gate is the complement of the upper gate. For either gate, a turn-on is delayed by `dead_band` times DB_PRESCALE clocks and a turn-off is not delayed. With a dead band of D clocks and pulses longer than D, both gates of a leg are low for 2D clocks of every carrier cycle.
- R6: The upper and lower gate of one leg are never high in the same clock.
- R7: With `bipolar` = 1, the right leg's duty is `period - duty_left`, or 0 when `duty_left` exceeds `period`, and `duty_right` is ignored.
- R8: During reset, and from the clock after `enable` is sampled low, all four gates and `adc_soc` are low and the carriers, shadows and compare values are zero. On re-enable, `adc_soc` is high in the first clock after `enable` is sampled high.
- R9: The carrier period is captured only at the zero point, so a period change made in a strobe clock leaves the current cycle at 2·old clocks and makes the next cycle 2·new clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low forces all gates low and clears state |
| bipolar | input | 1 | 1: right leg duty is period minus left duty |
| period | input | CNT_W | Carrier peak value P (cycle = 2P clocks) |
| duty_left | input | CNT_W | Left leg compare command |
| duty_right | input | CNT_W | Right leg compare command (unipolar mode) |
| dead_band | input | DB_W | Dead interval in units of DB_PRESCALE clocks |
| gate_left_hi | output | 1 | Left leg upper switch gate |
| gate_left_lo | output | 1 | Left leg lower switch gate |
| gate_right_hi | output | 1 | Right leg upper switch gate |
| gate_right_lo | output | 1 | Right leg lower switch gate |
| adc_soc | output | 1 | One-clock start-of-conversion strobe per carrier cycle |

## Verification
Several properties are checked on every cycle:
- each leg never drives both switches on at once;
- each carrier stays within its latched period;
- the strobe is a single pulse that follows a zero value, and both carriers strobe together;
- a compare value changes only at a zero point or while disabled;
- a gate only turns on after its request was present;
- every gate drops once `enable` is sampled low.

Only the bench scenarios show the actual pulse widths per cycle, the one-cycle lag of shadowed duty and period changes, the length of the dead interval, and the bipolar complement with its saturation. A behavioural model, compared on every clock, covers the exact edge timing.

// File: rtl/hbpwm_pkg.sv
// Package hbpwm_pkg
// Shared constants for the dual-carrier H-bridge PWM generator.
// Assumes exactly two bridge legs; leg 0 is the left leg, leg 1 the right.
package hbpwm_pkg;
    localparam int LEGS      = 2;
    localparam int LEG_LEFT  = 0;
    localparam int LEG_RIGHT = 1;
endpackage

// File: rtl/hbpwm_carrier.sv
// Module hbpwm_carrier
// Triangular carrier: counts 0 up to the latched period and back to 0.
// The period is captured only at the zero point. at_zero_o flags the zero
// clock; soc_o pulses one clock later. Assumes period_in >= 1 for running.
module hbpwm_carrier #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_zero_o,
    output logic             soc_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_act;
    logic             rising;

    assign cnt_o     = cnt;
    assign at_zero_o = (cnt == '0);

    // Purpose: advance the up/down counter and latch the period at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt     <= '0;
            per_act <= '0;
            rising  <= 1'b1;
            soc_o   <= 1'b0;
        end else begin
            soc_o <= (cnt == '0) && (period_in != '0);
            if (cnt == '0) begin
                per_act <= period_in;
                rising  <= 1'b1;
                if (period_in != '0) begin
                    cnt <= cnt + 1'b1;
                end
            end else if (rising && (cnt >= per_act)) begin
                cnt    <= cnt - 1'b1;
                rising <= 1'b0;
            end else if (rising) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R1: counter never exceeds the period it latched
    p_cnt_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_act)
        else $error("carrier above latched period");

    // R2: strobe is a single clock wide
    p_soc_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soc_o |=> !soc_o)
        else $error("strobe wider than one clock");

    // R2: strobe only follows a zero value
    p_soc_after_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soc_o |-> $past(cnt == '0))
        else $error("strobe without zero point");
endmodule

// File: rtl/hbpwm_cmp.sv
// Module hbpwm_cmp
// Compare unit of one leg: a shadow register sampled every clock and an
// active compare register loaded from the shadow at the carrier zero point.
// raw_o requests the upper switch while the carrier is below the active value.
module hbpwm_cmp #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             at_zero_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             raw_o
);
    logic [CNT_W-1:0] shadow;
    logic [CNT_W-1:0] active;

    // Purpose: buffer the command and commit it at the zero point.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            shadow <= '0;
            active <= '0;
        end else begin
            shadow <= duty_i;
            if (at_zero_i) begin
                active <= shadow;
            end
        end
    end

    assign raw_o = (cnt_i < active);

    // R4: active compare changes only at a zero point or when disabled
    p_commit_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> ($past(at_zero_i) || $past(!en)))
        else $error("compare value changed outside zero point");
endmodule

// File: rtl/hbpwm_dband.sv
// Module hbpwm_dband
// Rising-edge delay for one gate: the output turns on once the request has
// been high for dly_i clocks beyond the register stage, and turns off the
// clock after the request drops. Assumes dly_i may change at any time.
module hbpwm_dband #(
    parameter int DLY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sig_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             gate_o
);
    logic [DLY_W-1:0] held;

    // Purpose: count how long the request has been high, release at dly_i.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !sig_i) begin
            held   <= '0;
            gate_o <= 1'b0;
        end else if (held >= dly_i) begin
            gate_o <= 1'b1;
        end else begin
            held <= held + 1'b1;
        end
    end

    // R5: a gate turns on only after its request was present
    p_rise_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(sig_i))
        else $error("gate turned on without request");
endmodule

// File: rtl/hbridge_pwm_gen.sv
// Module hbridge_pwm_gen
// Dual-leg symmetric PWM generator for a full-bridge chopper. Two identical
// triangular carriers, one per leg, each with a shadowed compare unit and a
// dead-banded complementary gate pair. Leg 0 raises the conversion strobe.
// Assumes period >= 1 while enabled; period 0 parks the carriers at zero.
module hbridge_pwm_gen #(
    parameter int CNT_W       = 12,
    parameter int DB_W        = 4,
    parameter int DB_PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bipolar,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty_left,
    input  logic [CNT_W-1:0] duty_right,
    input  logic [DB_W-1:0]  dead_band,
    output logic             gate_left_hi,
    output logic             gate_left_lo,
    output logic             gate_right_hi,
    output logic             gate_right_lo,
    output logic             adc_soc
);
    import hbpwm_pkg::*;

    localparam int DLY_W = DB_W + $clog2(DB_PRESCALE + 1);

    logic [CNT_W-1:0] cnt_w   [LEGS];
    logic             zero_w  [LEGS];
    logic             soc_w   [LEGS];
    logic             raw_w   [LEGS];
    logic [CNT_W-1:0] duty_w  [LEGS];
    logic             hi_w    [LEGS];
    logic             lo_w    [LEGS];
    logic [CNT_W-1:0] duty_inv;
    logic [DLY_W-1:0] dly;

    // Purpose: right-leg command for bipolar mode, saturated at zero.
    always_comb begin
        if (duty_left <= period) begin
            duty_inv = period - duty_left;
        end else begin
            duty_inv = '0;
        end
    end

    assign dly = DLY_W'(dead_band) * DLY_W'(DB_PRESCALE);
    assign duty_w[LEG_LEFT]  = duty_left;
    assign duty_w[LEG_RIGHT] = bipolar ? duty_inv : duty_right;

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        hbpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (enable),
            .period_in (period),
            .cnt_o     (cnt_w[g]),
            .at_zero_o (zero_w[g]),
            .soc_o     (soc_w[g])
        );

        hbpwm_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (enable),
            .cnt_i     (cnt_w[g]),
            .at_zero_i (zero_w[g]),
            .duty_i    (duty_w[g]),
            .raw_o     (raw_w[g])
        );

        hbpwm_dband #(.DLY_W(DLY_W)) u_db_hi (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (enable),
            .sig_i  (raw_w[g] & enable),
            .dly_i  (dly),
            .gate_o (hi_w[g])
        );

        hbpwm_dband #(.DLY_W(DLY_W)) u_db_lo (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (enable),
            .sig_i  (~raw_w[g] & enable),
            .dly_i  (dly),
            .gate_o (lo_w[g])
        );

        // R6: the two switches of one leg are never on together
        p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(hi_w[g] && lo_w[g]))
            else $error("shoot-through on leg");
    end

    assign gate_left_hi  = hi_w[LEG_LEFT];
    assign gate_left_lo  = lo_w[LEG_LEFT];
    assign gate_right_hi = hi_w[LEG_RIGHT];
    assign gate_right_lo = lo_w[LEG_RIGHT];
    assign adc_soc       = soc_w[LEG_LEFT];

    // R1: both carriers run in step, so their strobes coincide
    p_carriers_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        soc_w[LEG_LEFT] == soc_w[LEG_RIGHT])
        else $error("carriers out of step");

    // R8: disabling drops every gate and the strobe on the next clock
    p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(gate_left_hi || gate_left_lo || gate_right_hi || gate_right_lo || adc_soc))
        else $error("output active while disabled");
endmodule

// File: tb/tb_hbridge_pwm_gen.sv
`timescale 1ns/1ps
module tb_hbridge_pwm_gen;
    localparam int CW  = 12;
    localparam int DBW = 4;
    localparam int PRE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          bipolar = 1'b0;
    logic [CW-1:0] period = 12'd20;
    logic [CW-1:0] duty_left = 12'd8;
    logic [CW-1:0] duty_right = 12'd12;
    logic [DBW-1:0] dead_band = '0;
    logic gate_left_hi, gate_left_lo, gate_right_hi, gate_right_lo, adc_soc;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int overlaps = 0;
    bit mon_on = 1'b0;

    always #2.5 clk = ~clk;

    hbridge_pwm_gen #(.CNT_W(CW), .DB_W(DBW), .DB_PRESCALE(PRE)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bipolar(bipolar),
        .period(period), .duty_left(duty_left), .duty_right(duty_right),
        .dead_band(dead_band),
        .gate_left_hi(gate_left_hi), .gate_left_lo(gate_left_lo),
        .gate_right_hi(gate_right_hi), .gate_right_lo(gate_right_lo),
        .adc_soc(adc_soc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: carrier value, direction, latched period,
    // shadow and active compares, per-gate high-time counters (LH,LL,RH,RL).
    int m_cnt = 0, m_up = 1, m_per = 0, m_soc = 0;
    int m_sh[2] = '{0, 0};
    int m_cmp[2] = '{0, 0};
    int m_held[4] = '{0, 0, 0, 0};
    int m_gate[4] = '{0, 0, 0, 0};

    always @(posedge clk) begin : ref_model
        int req[4];
        int d;
        if (!rst_n || !enable) begin
            m_cnt = 0; m_up = 1; m_per = 0; m_soc = 0;
            m_sh = '{0, 0}; m_cmp = '{0, 0};
            m_held = '{0, 0, 0, 0}; m_gate = '{0, 0, 0, 0};
        end else begin
            d = int'(dead_band) * PRE;
            for (int l = 0; l < 2; l++) begin
                req[2*l]   = (m_cnt < m_cmp[l]) ? 1 : 0;
                req[2*l+1] = 1 - req[2*l];
            end
            for (int k = 0; k < 4; k++) begin
                if (req[k] == 0) begin
                    m_gate[k] = 0; m_held[k] = 0;
                end else if (m_held[k] >= d) begin
                    m_gate[k] = 1;
                end else begin
                    m_held[k]++;
                end
            end
            m_soc = (m_cnt == 0 && period != 0) ? 1 : 0;
            if (m_cnt == 0) begin
                m_cmp = m_sh;
                m_per = int'(period);
                m_up = 1;
                if (period != 0) m_cnt = 1;
            end else if (m_up == 1 && m_cnt >= m_per) begin
                m_cnt--; m_up = 0;
            end else if (m_up == 1) begin
                m_cnt++;
            end else begin
                m_cnt--;
            end
            m_sh[0] = int'(duty_left);
            if (bipolar)
                m_sh[1] = (duty_left <= period) ? int'(period) - int'(duty_left) : 0;
            else
                m_sh[1] = int'(duty_right);
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            chk(gate_left_hi == m_gate[0] && gate_right_hi == m_gate[2],
                "R3 upper gates vs model", {gate_left_hi, gate_right_hi}, {m_gate[0][0], m_gate[2][0]});
            chk(gate_left_lo == m_gate[1] && gate_right_lo == m_gate[3],
                "R5 lower gates vs model", {gate_left_lo, gate_right_lo}, {m_gate[1][0], m_gate[3][0]});
            chk(adc_soc == m_soc, "R2 strobe vs model", adc_soc, m_soc);
        end
        if ((gate_left_hi && gate_left_lo) || (gate_right_hi && gate_right_lo))
            overlaps++;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_soc();
        do @(negedge clk); while (!adc_soc);
    endtask

    // Caller stands on a strobe clock; counts clocks to the next strobe.
    task automatic soc_gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!adc_soc);
    endtask

    // Caller stands on a strobe clock; counts upper-gate high clocks over 2P-1.
    task automatic count_hi(input int p, output int nl, output int nr);
        nl = 0; nr = 0;
        for (int i = 1; i < 2*p; i++) begin
            @(negedge clk);
            nl += gate_left_hi;
            nr += gate_right_hi;
        end
    endtask

    initial begin
        int n1, n2, nl, nr, both_low, quiet;
        // R8: reset state
        idle(4);
        chk({gate_left_hi, gate_left_lo, gate_right_hi, gate_right_lo, adc_soc} == 5'b0,
            "R8 outputs low in reset", {gate_left_hi, gate_left_lo, gate_right_hi, gate_right_lo, adc_soc}, 0);
        rst_n = 1'b1;
        idle(3);
        chk({gate_left_hi, gate_left_lo, gate_right_hi, gate_right_lo, adc_soc} == 5'b0,
            "R8 outputs low while disabled", {gate_left_hi, gate_left_lo, gate_right_hi, gate_right_lo, adc_soc}, 0);
        mon_on = 1'b1;
        enable = 1'b1;
        idle(100);

        // R1: carrier cycle is 2P clocks
        wait_soc();
        soc_gap(n1);
        chk(n1 == 40, "R1 carrier cycle length", n1, 40);

        // R3: pulse widths for two duty values
        wait_soc();
        count_hi(20, nl, nr);
        chk(nl == 14, "R3 left width duty 8", nl, 14);
        chk(nr == 22, "R3 right width duty 12", nr, 22);
        duty_right = 12'd0;
        idle(100);
        wait_soc();
        count_hi(20, nl, nr);
        chk(nr == 0, "R3 duty 0 keeps gate low", nr, 0);

        // R4: duty written at a strobe takes effect one cycle later
        wait_soc();
        duty_left = 12'd3;
        count_hi(20, nl, nr);
        chk(nl == 14, "R4 current cycle keeps old duty", nl, 14);
        wait_soc();
        count_hi(20, nl, nr);
        chk(nl == 4, "R4 next cycle uses new duty", nl, 4);

        // R5: dead band of 2 units (8 clocks) on both turn-on edges
        duty_left = 12'd8;
        dead_band = 4'd2;
        idle(100);
        wait_soc();
        both_low = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!gate_left_hi && !gate_left_lo) both_low++;
        end
        chk(both_low == 16, "R5 dead interval per cycle", both_low, 16);
        dead_band = 4'd0;
        idle(100);

        // R9: period latched at zero point
        wait_soc();
        period = 12'd7;
        soc_gap(n1);
        soc_gap(n2);
        chk(n1 == 40, "R9 current cycle keeps old period", n1, 40);
        chk(n2 == 14, "R9 next cycle uses new period", n2, 14);

        // R7: bipolar complement
        period = 12'd16;
        bipolar = 1'b1;
        duty_right = 12'd1;
        idle(100);
        wait_soc();
        count_hi(16, nl, nr);
        chk(nl == 14 && nr == 14, "R7 mid-scale equal widths", nr, 14);
        duty_left = 12'd12;
        idle(100);
        wait_soc();
        count_hi(16, nl, nr);
        chk(nl == 22, "R7 left width duty 12", nl, 22);
        chk(nr == 6, "R7 right gets period minus duty", nr, 6);
        duty_left = 12'd20;
        idle(100);
        wait_soc();
        count_hi(16, nl, nr);
        chk(nr == 0, "R7 complement saturates at zero", nr, 0);
        chk(nl == 31, "R3 duty above period stays high", nl, 31);

        // R8: disable and re-enable
        enable = 1'b0;
        @(negedge clk);
        quiet = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (gate_left_hi || gate_left_lo || gate_right_hi || gate_right_lo || adc_soc) quiet++;
        end
        chk(quiet == 0, "R8 outputs low while disabled", quiet, 0);
        enable = 1'b1;
        @(negedge clk);
        chk(adc_soc == 1'b1, "R8 strobe right after re-enable", adc_soc, 1);
        idle(60);

        // R6: no leg ever had both switches on
        chk(overlaps == 0, "R6 no shoot-through", overlaps, 0);

        mon_on = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule